// File: doc/BRIEF.md
# Stereo Sample-Frame Converter Sequencer

This block drives the fixed control schedule of one audio sample frame around a single shared 16-bit DAC. In every frame it sends one left and one right output sample to the DAC. It also turns the same DAC into a successive-approximation converter that digitises one analog input. The DAC register is fed over an 8-bit bus and loaded by two strobes, one for the upper half and one for the lower half. An external comparator reports whether the input is at or above the DAC voltage.

At an 8 MHz clock a frame lasts 240 cycles, which gives a frame rate of about 33.3 kHz. The frame has three phases:

- **Sample (cycles 0 to 23).** The input track switch is closed. The left word is loaded into the DAC and the left hold strobe is active.
- **Settle (cycles 24 to 47).** The track switch is open. The right word is loaded into the DAC and the right hold strobe is active.
- **Convert (cycles 48 to 239).** Sixteen trials of 12 cycles each decide the input bits, starting at the most significant bit.

The schedule runs without a break for as long as the block is out of reset, whatever the inputs are doing.

Top module: `sfc_seq`

## Requirements
- R1: `frame_done` is high for exactly one cycle per frame, and there are exactly 240 cycles between pulses. The first pulse comes in cycle 0 of the second frame after reset, and the schedule never stalls.
- R2: `track_sw` and `hold_left` are both high in frame cycles 0 to 23 and low in every other cycle.
- R3: `hold_right` is high in frame cycles 24 to 47 and low in every other cycle. It is never high together with `hold_left`.
- R4: In each sample phase, settle phase and trial, the upper-byte strobe `hi_latch` is high only on the first cycle and carries bits 15:8 of the current DAC word on `dac_byte`. The lower-byte strobe `lo_latch` is high only on the second cycle and carries bits 7:0. The two strobes are never high together.
- R5: The DAC word is `left_word` during the sample phase and `right_word` during the settle phase.
- R6: Trial k (k = 0 to 15) starts at cycle 48+12k and decides bit 15-k. Its DAC word is the bits already decided, with bit 15-k set and all lower bits clear. `cmp_hi` is sampled only on the trial's last cycle (cycle 11 of the trial). A 1 keeps the bit and a 0 clears it.
- R7: `conv_word` takes the new conversion result in the same cycle that `frame_done` is high. It holds that value for the rest of the frame.
- R8: While reset is held, `conv_word` is 0, `frame_done` is 0, and the block presents frame cycle 0 (track switch closed, upper-byte strobe high). The first cycle after reset is released is frame cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the DAC voltage |
| left_word | input | 16 | Left output sample |
| right_word | input | 16 | Right output sample |
| dac_byte | output | 8 | Shared DAC byte bus |
| hi_latch | output | 1 | Latch strobe for DAC bits 15:8 |
| lo_latch | output | 1 | Latch strobe for DAC bits 7:0 |
| track_sw | output | 1 | Input track switch closed |
| hold_left | output | 1 | Left sample-and-hold strobe |
| hold_right | output | 1 | Right sample-and-hold strobe |
| conv_word | output | 16 | Last converted input word |
| frame_done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong phase or sub-cycle counter shows up within one phase. The strobes and the switch/hold windows move away from their fixed frame cycles, and a wrong frame length moves the next `frame_done` pulse. A wrong trial accumulator shows up on the DAC bus during the very next trial, because the trial code is driven out on the byte strobes. It also gives a wrong `conv_word` at the end of that frame. The comparator is driven with random values on every cycle except each trial's decision cycle, so sampling it on the wrong cycle corrupts the result within one frame.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int PHASE_CYC = 24;
    localparam int TRIAL_CYC = 12;

    function automatic int frame_cycles(input int bits, input int ph, input int tr);
        return 2 * ph + bits * tr;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int FRAME_CYC = frame_cycles(WORD_W, PHASE_CYC, TRIAL_CYC);

    typedef enum logic [1:0] {
        PH_SAMPLE  = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;

endpackage

// File: rtl/sfc_frame_timer.sv
module sfc_frame_timer
    import sfc_pkg::*;
#(
    parameter int WORD_W    = sfc_pkg::WORD_W,
    parameter int PHASE_CYC = sfc_pkg::PHASE_CYC,
    parameter int TRIAL_CYC = sfc_pkg::TRIAL_CYC,
    localparam int SUB_W    = $clog2(max2(PHASE_CYC, TRIAL_CYC)),
    localparam int TRL_W    = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    output phase_e           phase,
    output logic [SUB_W-1:0] sub,
    output logic [TRL_W-1:0] trial,
    output logic             trial_last,
    output logic             frame_last
);

    logic wrap;

    always_comb begin
        if (phase == PH_CONVERT)
            wrap = (sub == SUB_W'(TRIAL_CYC - 1));
        else
            wrap = (sub == SUB_W'(PHASE_CYC - 1));
    end

    assign trial_last = (phase == PH_CONVERT) && (sub == SUB_W'(TRIAL_CYC - 1));
    assign frame_last = trial_last && (trial == TRL_W'(WORD_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SAMPLE;
            sub   <= '0;
            trial <= '0;
        end else if (wrap) begin
            sub <= '0;
            case (phase)
                PH_SAMPLE: phase <= PH_SETTLE;
                PH_SETTLE: begin
                    phase <= PH_CONVERT;
                    trial <= '0;
                end
                default: begin
                    if (trial == TRL_W'(WORD_W - 1)) begin
                        phase <= PH_SAMPLE;
                        trial <= '0;
                    end else begin
                        trial <= trial + 1'b1;
                    end
                end
            endcase
        end else begin
            sub <= sub + 1'b1;
        end
    end

endmodule

// File: rtl/sfc_sar_core.sv
module sfc_sar_core
    import sfc_pkg::*;
#(
    parameter int WORD_W = sfc_pkg::WORD_W,
    localparam int TRL_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [TRL_W-1:0]  trial,
    input  logic              decide,
    input  logic              frame_last,
    input  logic              cmp_hi,
    output logic [WORD_W-1:0] trial_code,
    output logic [WORD_W-1:0] result,
    output logic              done
);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] mask;

    // Trial 0 tests the MSB; later trials walk down one bit each.
    assign mask       = WORD_W'(1) << (TRL_W'(WORD_W - 1) - trial);
    assign trial_code = acc | mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= frame_last;
            if (phase != PH_CONVERT)
                acc <= '0;
            else if (decide && cmp_hi)
                acc <= acc | mask;
            if (frame_last)
                result <= cmp_hi ? (acc | mask) : acc;
        end
    end

endmodule

// File: rtl/sfc_dac_mux.sv
module sfc_dac_mux
    import sfc_pkg::*;
#(
    parameter int BYTE_W  = sfc_pkg::BYTE_W,
    parameter int WORD_W  = sfc_pkg::WORD_W,
    parameter int SUB_W   = 5,
    localparam int LANES  = WORD_W / BYTE_W
) (
    input  phase_e            phase,
    input  logic [SUB_W-1:0]  sub,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic [WORD_W-1:0] trial_code,
    output logic [BYTE_W-1:0] dac_byte,
    output logic [LANES-1:0]  lane_stb,
    output logic              track_sw,
    output logic              hold_left,
    output logic              hold_right
);

    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] lane_byte [LANES];

    always_comb begin
        case (phase)
            PH_SAMPLE: word = left_word;
            PH_SETTLE: word = right_word;
            default:   word = trial_code;
        endcase
    end

    // Lane 0 is the most significant byte and goes out on the first cycle.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_stb[k]  = (sub == SUB_W'(k));
        assign lane_byte[k] = word[WORD_W-1-k*BYTE_W -: BYTE_W];
    end

    always_comb begin
        dac_byte = lane_byte[LANES-1];
        for (int k = 0; k < LANES; k++)
            if (lane_stb[k]) dac_byte = lane_byte[k];
    end

    assign track_sw   = (phase == PH_SAMPLE);
    assign hold_left  = (phase == PH_SAMPLE);
    assign hold_right = (phase == PH_SETTLE);

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int BYTE_W    = sfc_pkg::BYTE_W,
    parameter int PHASE_CYC = sfc_pkg::PHASE_CYC,
    parameter int TRIAL_CYC = sfc_pkg::TRIAL_CYC,
    localparam int WORD_W   = 2 * BYTE_W,
    localparam int SUB_W    = $clog2(max2(PHASE_CYC, TRIAL_CYC)),
    localparam int TRL_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_hi,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    output logic [BYTE_W-1:0] dac_byte,
    output logic              hi_latch,
    output logic              lo_latch,
    output logic              track_sw,
    output logic              hold_left,
    output logic              hold_right,
    output logic [WORD_W-1:0] conv_word,
    output logic              frame_done
);

    phase_e            phase;
    logic [SUB_W-1:0]  sub;
    logic [TRL_W-1:0]  trial;
    logic              trial_last;
    logic              frame_last;
    logic [WORD_W-1:0] trial_code;
    logic [1:0]        stb;

    sfc_frame_timer #(
        .WORD_W(WORD_W), .PHASE_CYC(PHASE_CYC), .TRIAL_CYC(TRIAL_CYC)
    ) u_timer (
        .clk(clk), .rst(rst), .phase(phase), .sub(sub), .trial(trial),
        .trial_last(trial_last), .frame_last(frame_last)
    );

    sfc_sar_core #(.WORD_W(WORD_W)) u_sar (
        .clk(clk), .rst(rst), .phase(phase), .trial(trial),
        .decide(trial_last), .frame_last(frame_last), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .result(conv_word), .done(frame_done)
    );

    sfc_dac_mux #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .SUB_W(SUB_W)) u_mux (
        .phase(phase), .sub(sub), .left_word(left_word), .right_word(right_word),
        .trial_code(trial_code), .dac_byte(dac_byte), .lane_stb(stb),
        .track_sw(track_sw), .hold_left(hold_left), .hold_right(hold_right)
    );

    assign hi_latch = stb[0];
    assign lo_latch = stb[1];

endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk
    import sfc_pkg::*;
#(
    parameter int WORD_W    = sfc_pkg::WORD_W,
    parameter int FRAME_LEN = sfc_pkg::FRAME_CYC
) (
    input logic              clk,
    input logic              rst,
    input logic              hi_latch,
    input logic              lo_latch,
    input logic              track_sw,
    input logic              hold_left,
    input logic              hold_right,
    input logic              frame_done,
    input logic [WORD_W-1:0] conv_word
);

    logic [15:0] since;

    always_ff @(posedge clk) begin
        if (rst)             since <= '0;
        else if (frame_done) since <= 16'd1;
        else                 since <= since + 16'd1;
    end

    assert_frame_len_R1: assert property (@(posedge clk) disable iff (rst)
        frame_done == (since == 16'(FRAME_LEN)));

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_right_after_track_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(track_sw) |-> hold_right);

    assert_holds_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(hold_left && hold_right));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(hi_latch && lo_latch));

    assert_hi_then_lo_R4: assert property (@(posedge clk) disable iff (rst)
        hi_latch |=> lo_latch);

    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_done |-> $stable(conv_word));

endmodule

bind sfc_seq sfc_seq_chk u_chk (
    .clk(clk), .rst(rst), .hi_latch(hi_latch), .lo_latch(lo_latch),
    .track_sw(track_sw), .hold_left(hold_left), .hold_right(hold_right),
    .frame_done(frame_done), .conv_word(conv_word)
);

// File: tb/sfc_seq_tb_top.sv
module sfc_seq_tb_top;

    localparam int CLK_PERIOD = 125;
    localparam int FRAME      = 240;
    localparam int NFRAMES    = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_hi = 1'b0;
    logic [15:0] left_word = '0;
    logic [15:0] right_word = '0;
    logic [7:0]  dac_byte;
    logic        hi_latch, lo_latch, track_sw, hold_left, hold_right, frame_done;
    logic [15:0] conv_word;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sfc_seq dut_i (
        .clk(clk), .rst(rst), .cmp_hi(cmp_hi), .left_word(left_word),
        .right_word(right_word), .dac_byte(dac_byte), .hi_latch(hi_latch),
        .lo_latch(lo_latch), .track_sw(track_sw), .hold_left(hold_left),
        .hold_right(hold_right), .conv_word(conv_word), .frame_done(frame_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sub-cycle inside the current phase or trial.
    function automatic int sub_of(input int fc);
        if (fc < 24) return fc;
        if (fc < 48) return fc - 24;
        return (fc - 48) % 12;
    endfunction

    // Expected DAC word for a correct conversion of x.
    function automatic logic [15:0] word_of(input int fc, input logic [15:0] l,
                                            input logic [15:0] r, input logic [15:0] x);
        int k, b;
        int unsigned upper;
        if (fc < 24) return l;
        if (fc < 48) return r;
        k = (fc - 48) / 12;
        b = 15 - k;
        upper = int'(x) & ~((32'd1 << (b + 1)) - 1);
        return 16'(upper | (32'd1 << b));
    endfunction

    function automatic logic [15:0] pick_x(input int f);
        case (f)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h7FFF;
            4: return 16'h5555;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        int unsigned seed_dummy;
        logic [15:0] x, x_prev, held, latch;
        int fc;
        seed_dummy = $urandom(32'd20240611);
        x = pick_x(0);
        x_prev = '0;
        held = '0;
        latch = '0;
        left_word  = 16'hA5C3;
        right_word = 16'h3C5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: values while reset is held
        chk("R8", "conv_word in reset", int'(conv_word), 0);
        chk("R8", "frame_done in reset", int'(frame_done), 0);
        chk("R8", "track_sw in reset", int'(track_sw), 1);
        chk("R8", "hi_latch in reset", int'(hi_latch), 1);
        rst = 1'b0;
        for (int f = 0; f < NFRAMES; f++) begin
            for (fc = 0; fc < FRAME; fc++) begin
                int s;
                logic [15:0] w;
                s = sub_of(fc);
                w = word_of(fc, left_word, right_word, x);
                chk("R2", "track_sw", int'(track_sw), int'(fc < 24));
                chk("R2", "hold_left", int'(hold_left), int'(fc < 24));
                chk("R3", "hold_right", int'(hold_right), int'(fc >= 24 && fc < 48));
                chk("R4", "hi_latch", int'(hi_latch), int'(s == 0));
                chk("R4", "lo_latch", int'(lo_latch), int'(s == 1));
                if (s == 0) begin
                    chk(fc < 48 ? "R5" : "R6", "upper byte", int'(dac_byte), int'(w[15:8]));
                    latch[15:8] = dac_byte;
                end
                if (s == 1) begin
                    chk(fc < 48 ? "R5" : "R6", "lower byte", int'(dac_byte), int'(w[7:0]));
                    latch[7:0] = dac_byte;
                end
                if (fc == 2)  chk("R5", "left in DAC", int'(latch), int'(left_word));
                if (fc == 26) chk("R5", "right in DAC", int'(latch), int'(right_word));
                if (fc == 0 && f > 0) begin
                    held = x_prev;
                    chk("R1", "frame_done at frame start", int'(frame_done), 1);
                end else begin
                    chk("R1", "frame_done off", int'(frame_done), 0);
                end
                chk("R7", "conv_word", int'(conv_word), int'(held));
                // R6: comparator is meaningful only on each trial's last cycle
                if (fc >= 48 && s == 11) cmp_hi = (latch <= x);
                else                     cmp_hi = 1'($urandom);
                if (fc == FRAME - 1) begin
                    x_prev = x;
                    x = pick_x(f + 1);
                    left_word  = 16'($urandom);
                    right_word = (f == 3) ? 16'hFFFF : 16'($urandom);
                end
                @(negedge clk);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule